// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token latches that two independent ports share. Software on either side claims a shared resource by writing a request to a token and then reading the token back. A read returns 0 only to the port that holds the token, and 1 to the other port or to anyone when the token is free. Writing 1 gives the token back. If it comes from a port that does not hold the token, writing 1 withdraws that port's request instead.

Each token also remembers one waiting request from each side. When the owner releases a token that the other side has asked for, ownership passes straight to the waiting side and the token never becomes free in between. A port reaches the tokens only when its memory enable is inactive and its semaphore select is active. The low address bits pick the token and the upper bits are ignored. A read captures the token's value in a per-port output register and drives it on every data bit.

Top module: `sem_bank`

## Requirements
- R1: After reset every token is free and nothing is pending, so reads of all tokens from both ports return all ones.
- R2: A port that writes 0 to a free token owns it. Its reads of that token then return all zeros, and the other port reads all ones.
- R3: A 0 written by the non-owner does not take the token away. The owner still reads 0 and the requester still reads 1.
- R4: If the non-owner has a request pending, ownership moves to it in the same cycle that the owner writes 1. It then reads 0 and the old owner reads 1.
- R5: A release with no pending request frees the token, and both ports then read all ones.
- R6: A 1 written by the non-owner cancels its pending request. A later release by the owner then frees the token.
- R7: A write uses only data bit 0, where 0 means request and 1 means release or cancel. A read returns the token value on every data bit, so the read data is all zeros or all ones.
- R8: The token index is address bits [2:0]. Higher address bits have no effect on which token is accessed.
- R9: When memory enable is high or semaphore select is low, the port's write changes no token and its read data register keeps its value.
- R10: If both ports request a free token in the same cycle, the left port gets it and the right port's request is recorded as pending.
- R11: The read data register loads on the clock edge that ends a read access. It holds the token state from before any write made by the other port in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_mem_en | input | 1 | Left memory enable (must be low for token access) |
| l_sel | input | 1 | Left semaphore select |
| l_we | input | 1 | Left write strobe |
| l_addr | input | AW | Left address, bits [2:0] select the token |
| l_wd | input | DW | Left write data, bit 0 used |
| l_rd | output | DW | Left registered read data |
| r_mem_en | input | 1 | Right memory enable (must be low for token access) |
| r_sel | input | 1 | Right semaphore select |
| r_we | input | 1 | Right write strobe |
| r_addr | input | AW | Right address, bits [2:0] select the token |
| r_wd | input | DW | Right write data, bit 0 used |
| r_rd | output | DW | Right registered read data |

## Verification
A wrong owner or pending bit shows up the first time either port reads that token: the read data register shows the wrong polarity one edge after the read access. A lost pending request stays hidden until the owner releases. It then appears as all ones on the waiting side where zeros were expected, so the bench reads both sides after every release. Same-cycle cases are driven as single combined cycles: both sides requesting together, and a read racing a hand-off. This is because an error in ordering only appears in those cycles.

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NSEM = 8,
  parameter int AW   = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_mem_en,
  input  logic          l_sel,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wd,
  output logic [DW-1:0] l_rd,
  input  logic          r_mem_en,
  input  logic          r_sel,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wd,
  output logic [DW-1:0] r_rd
);
  localparam int IW = $clog2(NSEM);
  localparam logic [1:0] T_FREE  = 2'd0;
  localparam logic [1:0] T_LEFT  = 2'd1;
  localparam logic [1:0] T_RIGHT = 2'd2;

  logic [NSEM-1:0][1:0] own_q, own_n;
  logic [NSEM-1:0]      pl_q, pl_n, pr_q, pr_n;
  logic [DW-1:0]        l_rd_q, r_rd_q;

  wire          l_acc = l_sel && !l_mem_en;
  wire          r_acc = r_sel && !r_mem_en;
  wire          l_wr  = l_acc && l_we;
  wire          r_wr  = r_acc && r_we;
  wire [IW-1:0] li    = l_addr[IW-1:0];
  wire [IW-1:0] ri    = r_addr[IW-1:0];

  // Left write is applied first, which gives it priority on a free token.
  always_comb begin
    own_n = own_q;
    pl_n  = pl_q;
    pr_n  = pr_q;
    if (l_wr) begin
      if (!l_wd[0]) begin
        if (own_n[li] == T_FREE)       own_n[li] = T_LEFT;
        else if (own_n[li] == T_RIGHT) pl_n[li]  = 1'b1;
      end else if (own_n[li] == T_LEFT) begin
        if (pr_n[li]) begin
          own_n[li] = T_RIGHT;
          pr_n[li]  = 1'b0;
        end else begin
          own_n[li] = T_FREE;
        end
      end else begin
        pl_n[li] = 1'b0;
      end
    end
    if (r_wr) begin
      if (!r_wd[0]) begin
        if (own_n[ri] == T_FREE)      own_n[ri] = T_RIGHT;
        else if (own_n[ri] == T_LEFT) pr_n[ri]  = 1'b1;
      end else if (own_n[ri] == T_RIGHT) begin
        if (pl_n[ri]) begin
          own_n[ri] = T_LEFT;
          pl_n[ri]  = 1'b0;
        end else begin
          own_n[ri] = T_FREE;
        end
      end else begin
        pr_n[ri] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q  <= '0;
      pl_q   <= '0;
      pr_q   <= '0;
      l_rd_q <= '1;
      r_rd_q <= '1;
    end else begin
      own_q <= own_n;
      pl_q  <= pl_n;
      pr_q  <= pr_n;
      if (l_acc && !l_we) l_rd_q <= {DW{own_q[li] != T_LEFT}};
      if (r_acc && !r_we) r_rd_q <= {DW{own_q[ri] != T_RIGHT}};
    end
  end

  assign l_rd = l_rd_q;
  assign r_rd = r_rd_q;
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NSEM = 8,
  parameter int AW   = 8,
  parameter int DW   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 l_mem_en,
  input logic                 l_sel,
  input logic                 l_we,
  input logic [AW-1:0]        l_addr,
  input logic [DW-1:0]        l_wd,
  input logic [DW-1:0]        l_rd,
  input logic                 r_mem_en,
  input logic                 r_sel,
  input logic                 r_we,
  input logic [AW-1:0]        r_addr,
  input logic [DW-1:0]        r_wd,
  input logic [DW-1:0]        r_rd,
  input logic [NSEM-1:0][1:0] own_q,
  input logic [NSEM-1:0]      pl_q,
  input logic [NSEM-1:0]      pr_q
);
  localparam int IW = $clog2(NSEM);
  logic l_read, r_read, l_write, r_write;
  logic [IW-1:0] lx, rx;
  assign l_read  = l_sel && !l_mem_en && !l_we;
  assign r_read  = r_sel && !r_mem_en && !r_we;
  assign l_write = l_sel && !l_mem_en && l_we;
  assign r_write = r_sel && !r_mem_en && r_we;
  assign lx = l_addr[IW-1:0];
  assign rx = r_addr[IW-1:0];

  a_r9_l_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !l_read |=> $stable(l_rd));
  a_r9_r_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !r_read |=> $stable(r_rd));
  a_r7_l_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd == '0) || (l_rd == '1));
  a_r7_r_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (r_rd == '0) || (r_rd == '1));
  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (l_read && r_read && lx == rx) |=> !(l_rd[0] == 1'b0 && r_rd[0] == 1'b0));
  a_r4_handoff_left: assert property (@(posedge clk) disable iff (!rst_n)
    (r_write && r_wd[0] && own_q[rx] == 2'd2 && pl_q[rx] && !(l_write && lx == rx))
    |=> own_q[$past(rx)] == 2'd1);
  a_r4_handoff_right: assert property (@(posedge clk) disable iff (!rst_n)
    (l_write && l_wd[0] && own_q[lx] == 2'd1 && pr_q[lx] && !(r_write && rx == lx))
    |=> own_q[$past(lx)] == 2'd2);

  for (genvar i = 0; i < NSEM; i++) begin : g_tok
    a_r5_free_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      own_q[i] == 2'd0 |-> (!pl_q[i] && !pr_q[i]));
    a_r3_owner_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q[i] == 2'd1 |-> !pl_q[i]) and (own_q[i] == 2'd2 |-> !pr_q[i]));
  end
endmodule

bind sem_bank sem_bank_chk #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_mem_en(l_mem_en), .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wd(l_wd), .l_rd(l_rd),
  .r_mem_en(r_mem_en), .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wd(r_wd), .r_rd(r_rd),
  .own_q(own_q), .pl_q(pl_q), .pr_q(pr_q)
);

// File: tb/sim_sem_bank.sv
`timescale 1ns/1ps
module sim_sem_bank;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [DW-1:0] ZERO = '0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_mem_en = 1'b0, l_sel = 1'b0, l_we = 1'b0;
  logic r_mem_en = 1'b0, r_sel = 1'b0, r_we = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wd = '0, r_wd = '0;
  logic [DW-1:0] l_rd, r_rd;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  sem_bank #(.NSEM(8), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .l_mem_en(l_mem_en), .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_wd(l_wd), .l_rd(l_rd),
    .r_mem_en(r_mem_en), .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_wd(r_wd), .r_rd(r_rd)
  );

  task automatic expect_eq(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 1'b0; l_we = 1'b0; l_mem_en = 1'b0;
    r_sel = 1'b0; r_we = 1'b0; r_mem_en = 1'b0;
  endtask

  // One cycle with optional accesses on both sides; returns at the next falling edge.
  task automatic cyc(input logic lv, input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                     input logic rv, input logic rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
    l_sel = lv; l_we = lw; l_addr = la; l_wd = ld;
    r_sel = rv; r_we = rw; r_addr = ra; r_wd = rd;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input bit right, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (right) cyc(1'b0, 1'b0, '0, '0, 1'b1, 1'b1, a, d);
    else       cyc(1'b1, 1'b1, a, d, 1'b0, 1'b0, '0, '0);
  endtask

  task automatic chk(input bit right, input logic [AW-1:0] a, input bit exp, input string tag);
    if (right) begin
      cyc(1'b0, 1'b0, '0, '0, 1'b1, 1'b0, a, '0);
      expect_eq(tag, r_rd, {DW{exp}});
    end else begin
      cyc(1'b1, 1'b0, a, '0, 1'b0, 1'b0, '0, '0);
      expect_eq(tag, l_rd, {DW{exp}});
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) begin
      chk(1'b0, AW'(i), 1'b1, "R1 left free after reset");
      chk(1'b1, AW'(i), 1'b1, "R1 right free after reset");
    end
  endtask

  task automatic t_take_queue_release();
    wr(1'b0, 8'd3, ZERO);
    chk(1'b0, 8'd3, 1'b0, "R2 left owns");
    chk(1'b1, 8'd3, 1'b1, "R2 right sees taken");
    wr(1'b1, 8'd3, ZERO);
    chk(1'b0, 8'd3, 1'b0, "R3 owner kept");
    chk(1'b1, 8'd3, 1'b1, "R3 requester waits");
    wr(1'b0, 8'd3, ONES);
    chk(1'b1, 8'd3, 1'b0, "R4 right handed token");
    chk(1'b0, 8'd3, 1'b1, "R4 old owner reads 1");
    wr(1'b1, 8'd3, ONES);
    chk(1'b0, 8'd3, 1'b1, "R5 left sees free");
    chk(1'b1, 8'd3, 1'b1, "R5 right sees free");
  endtask

  task automatic t_cancel();
    wr(1'b1, 8'd5, ZERO);
    wr(1'b0, 8'd5, ZERO);
    wr(1'b0, 8'd5, ONES);
    wr(1'b1, 8'd5, ONES);
    chk(1'b0, 8'd5, 1'b1, "R6 cancelled request not granted");
    chk(1'b1, 8'd5, 1'b1, "R6 token free after release");
  endtask

  task automatic t_bit0();
    wr(1'b0, 8'd1, 8'hFE);
    chk(1'b0, 8'd1, 1'b0, "R7 bit0 zero requests");
    wr(1'b0, 8'd1, 8'h01);
    chk(1'b0, 8'd1, 1'b1, "R7 bit0 one releases");
  endtask

  task automatic t_addr();
    wr(1'b0, 8'hA2, ZERO);
    chk(1'b0, 8'h02, 1'b0, "R8 upper bits ignored on write");
    chk(1'b1, 8'h5A, 1'b1, "R8 upper bits ignored on read");
    chk(1'b0, 8'h03, 1'b1, "R8 neighbour token untouched");
    wr(1'b0, 8'hF2, ONES);
    chk(1'b1, 8'd2, 1'b1, "R8 release via aliased address");
  endtask

  task automatic t_gating();
    l_mem_en = 1'b1;
    cyc(1'b1, 1'b1, 8'd4, ZERO, 1'b0, 1'b0, '0, '0);
    chk(1'b0, 8'd4, 1'b1, "R9 write with memory enable ignored");
    cyc(1'b0, 1'b1, 8'd4, ZERO, 1'b0, 1'b0, '0, '0);
    chk(1'b1, 8'd4, 1'b1, "R9 write without select ignored");
    wr(1'b0, 8'd6, ZERO);
    chk(1'b0, 8'd6, 1'b0, "R9 setup read zero");
    l_mem_en = 1'b1;
    cyc(1'b1, 1'b0, 8'd0, ZERO, 1'b0, 1'b0, '0, '0);
    expect_eq("R9 read data held under memory enable", l_rd, ZERO);
    wr(1'b0, 8'd6, ONES);
  endtask

  task automatic t_tie();
    cyc(1'b1, 1'b1, 8'd7, ZERO, 1'b1, 1'b1, 8'd7, ZERO);
    chk(1'b0, 8'd7, 1'b0, "R10 left wins tie");
    chk(1'b1, 8'd7, 1'b1, "R10 right loses tie");
    wr(1'b0, 8'd7, ONES);
    chk(1'b1, 8'd7, 1'b0, "R10 right request was queued");
    wr(1'b1, 8'd7, ONES);
  endtask

  task automatic t_race();
    wr(1'b0, 8'd0, ZERO);
    wr(1'b1, 8'd0, ZERO);
    cyc(1'b1, 1'b1, 8'd0, ONES, 1'b1, 1'b0, 8'd0, ZERO);
    expect_eq("R11 read captures state before same-cycle write", r_rd, ONES);
    chk(1'b1, 8'd0, 1'b0, "R11 next read shows hand-off");
    wr(1'b1, 8'd0, ONES);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_eq("R1 left read register after reset", l_rd, ONES);
    expect_eq("R1 right read register after reset", r_rd, ONES);
    t_reset();
    t_take_queue_release();
    t_cancel();
    t_bit0();
    t_addr();
    t_gating();
    t_tie();
    t_race();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule